// File: doc/BRIEF.md
# LCD Line and Frame Timing Generator

This block paces the row scan of a multiplexed LCD driver. Each line event advances a common-row index, and the block gives a one-cycle strobe to the display data latch. It also produces the alternating-polarity frame signal. With this two-frame drive the polarity changes once per frame, when the row index returns from the last line to the first. Line events come from an internal oscillator tick or from the line clock pin, depending on which source is selected.

Two static straps set the block's role. One strap marks the chip as master or slave. The other strap picks the internal or the external line-clock source. From these straps the block enables the internal oscillator and sets an output enable for each of the three shared timing pins: frame polarity, line clock and display-off. A master drives the frame polarity and the display state from its own control bit. A slave receives both signals and restarts its row scan whenever the received polarity changes, so it stays in step with the master.

Top module: `lcd_frame_timing`

## Requirements
- R1: `osc_en` is 1 only when `strap_master`=1 and `strap_int_clk`=1.
- R2: With `strap_master`=1, `fr_oe` and `dof_oe` are 1 whatever `strap_int_clk` is, and `cl_oe` equals `strap_int_clk`.
- R3: With `strap_master`=0, `fr_oe`, `cl_oe` and `dof_oe` are all 0.
- R4: A line event is an `osc_tick` pulse when `osc_en`=1, and otherwise a rising edge of `cl_in`. `cl_in` has no effect while `osc_en`=1, and `osc_tick` has no effect while `osc_en`=0.
- R5: After reset, `line_idx`=1, `fr`=0, `line_strobe`=0 and `cl_out`=0.
- R6: On the clock edge that samples a line event, `line_idx` advances by one and `line_strobe` is 1 for that cycle only. With no event and no restart, `line_idx` holds and `line_strobe` is 0.
- R7: A line event at `line_idx`=LINES (default 65) sets `line_idx` to 1.
- R8: In master mode, `fr` inverts on the edge that wraps `line_idx` from LINES to 1 and at no other time.
- R9: `cl_out` pulses together with `line_strobe` when `osc_en`=1, and it is 0 otherwise.
- R10: In slave mode, `fr` follows `fr_in` one clock later. Any change of `fr_in` sets `line_idx` to 1 on that edge, even when a line event occurs on the same edge.
- R11: `dof_out` equals `disp_on`. `disp_en` equals `disp_on` in master mode and `dof_in` in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_master | input | 1 | 1 = master, 0 = slave |
| strap_int_clk | input | 1 | 1 = internal line-clock source selected |
| osc_tick | input | 1 | One-cycle tick from the internal oscillator |
| cl_in | input | 1 | Line clock received from the pin |
| fr_in | input | 1 | Frame polarity received from the pin |
| dof_in | input | 1 | Display-on level received from the pin |
| disp_on | input | 1 | Display-on control bit |
| osc_en | output | 1 | Internal oscillator enable |
| cl_oe | output | 1 | Line clock pin output enable |
| fr_oe | output | 1 | Frame polarity pin output enable |
| dof_oe | output | 1 | Display-off pin output enable |
| cl_out | output | 1 | Line clock driven to the pin |
| fr_out | output | 1 | Frame polarity driven to the pin |
| dof_out | output | 1 | Display-on level driven to the pin |
| fr | output | 1 | Frame polarity in effect |
| disp_en | output | 1 | Display enable in effect |
| line_idx | output | $clog2(LINES+1) | Current common row, 1..LINES |
| line_strobe | output | 1 | Data latch strobe, one cycle per line |

## Verification
The strap decode and the display-enable selection are combinational, so the bench checks them in the same cycle that it sets the straps. A line event or an `fr_in` change is driven at a falling clock edge. Its result appears in `line_idx`, `line_strobe`, `cl_out` and `fr` after the next rising edge, and the bench samples 2 ns after that edge. It then samples one edge later to confirm that the strobe has dropped. The expected row and polarity come from a counter model in the bench, stepped through several full frames of a seven-line configuration in each clock-source mode.

// File: rtl/lft_pkg.sv
package lft_pkg;
  typedef enum logic [1:0] {
    ROLE_MASTER_OSC = 2'd0,
    ROLE_MASTER_EXT = 2'd1,
    ROLE_SLAVE      = 2'd2
  } lft_role_e;
endpackage

// File: rtl/lft_rst_sync.sv
module lft_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/lft_pin_dir.sv
module lft_pin_dir
  import lft_pkg::*;
(
  input  logic      strap_master,
  input  logic      strap_int_clk,
  output lft_role_e role,
  output logic      osc_en,
  output logic      cl_oe,
  output logic      fr_oe,
  output logic      dof_oe
);
  always_comb begin
    if (!strap_master)      role = ROLE_SLAVE;
    else if (strap_int_clk) role = ROLE_MASTER_OSC;
    else                    role = ROLE_MASTER_EXT;
  end

  always_comb begin
    osc_en = 1'b0;
    cl_oe  = 1'b0;
    fr_oe  = 1'b0;
    dof_oe = 1'b0;
    unique case (role)
      ROLE_MASTER_OSC: begin
        osc_en = 1'b1;
        cl_oe  = 1'b1;
        fr_oe  = 1'b1;
        dof_oe = 1'b1;
      end
      ROLE_MASTER_EXT: begin
        fr_oe  = 1'b1;
        dof_oe = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lft_edge_sense.sv
module lft_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic slave,
  input  logic osc_tick,
  input  logic cl_in,
  input  logic fr_in,
  output logic line_evt,
  output logic fr_chg,
  output logic fr_rx
);
  logic cl_q;
  logic cl_d;
  logic fr_d;

  always_comb begin
    cl_d     = cl_in;
    fr_d     = fr_in;
    line_evt = osc_en ? osc_tick : (cl_in & ~cl_q);
    fr_chg   = slave & (fr_in ^ fr_rx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q  <= 1'b0;
      fr_rx <= 1'b0;
    end else begin
      cl_q  <= cl_d;
      fr_rx <= fr_d;
    end
  end
endmodule

// File: rtl/lft_line_ctr.sv
module lft_line_ctr #(
  parameter int LINES = 65,
  localparam int LW   = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          restart,
  input  logic          fr_gen_en,
  output logic [LW-1:0] line_idx,
  output logic          strobe,
  output logic          fr_q
);
  localparam logic [LW-1:0] FIRST = LW'(1);
  localparam logic [LW-1:0] LAST  = LW'(LINES);

  logic [LW-1:0] line_d;
  logic          strobe_d;
  logic          fr_d;
  logic          at_last;
  logic          upd_en;

  always_comb begin
    at_last  = (line_idx == LAST);
    upd_en   = adv | restart;
    strobe_d = adv;
    line_d   = line_idx;
    fr_d     = fr_q;
    if (restart) begin
      line_d = FIRST;
    end else if (adv) begin
      if (at_last) begin
        line_d = FIRST;
        if (fr_gen_en) fr_d = ~fr_q;
      end else begin
        line_d = line_idx + FIRST;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_idx <= FIRST;
      fr_q     <= 1'b0;
    end else if (upd_en) begin
      line_idx <= line_d;
      fr_q     <= fr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= strobe_d;
  end

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !restart && line_idx != LAST) |=> (line_idx == $past(line_idx) + FIRST) && strobe);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart) |=> $stable(line_idx) && !strobe);
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !restart && line_idx == LAST) |=> line_idx == FIRST);
  a_r8_fr_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fr_q) |-> (line_idx == FIRST) && strobe);
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> line_idx == FIRST);
  a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
    (line_idx >= FIRST) && (line_idx <= LAST));
endmodule

// File: rtl/lcd_frame_timing.sv
module lcd_frame_timing
  import lft_pkg::*;
#(
  parameter int LINES = 65,
  localparam int LW   = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_master,
  input  logic          strap_int_clk,
  input  logic          osc_tick,
  input  logic          cl_in,
  input  logic          fr_in,
  input  logic          dof_in,
  input  logic          disp_on,
  output logic          osc_en,
  output logic          cl_oe,
  output logic          fr_oe,
  output logic          dof_oe,
  output logic          cl_out,
  output logic          fr_out,
  output logic          dof_out,
  output logic          fr,
  output logic          disp_en,
  output logic [LW-1:0] line_idx,
  output logic          line_strobe
);
  lft_role_e role;
  logic      rst_sync_n;
  logic      slave;
  logic      line_evt;
  logic      fr_chg;
  logic      fr_rx;
  logic      fr_gen;
  logic      cl_out_d;

  lft_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lft_pin_dir u_dir (
    .strap_master  (strap_master),
    .strap_int_clk (strap_int_clk),
    .role          (role),
    .osc_en        (osc_en),
    .cl_oe         (cl_oe),
    .fr_oe         (fr_oe),
    .dof_oe        (dof_oe)
  );

  assign slave = (role == ROLE_SLAVE);

  lft_edge_sense u_sense (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .osc_en   (osc_en),
    .slave    (slave),
    .osc_tick (osc_tick),
    .cl_in    (cl_in),
    .fr_in    (fr_in),
    .line_evt (line_evt),
    .fr_chg   (fr_chg),
    .fr_rx    (fr_rx)
  );

  lft_line_ctr #(.LINES(LINES)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adv       (line_evt),
    .restart   (fr_chg),
    .fr_gen_en (~slave),
    .line_idx  (line_idx),
    .strobe    (line_strobe),
    .fr_q      (fr_gen)
  );

  always_comb begin
    cl_out_d = line_evt & osc_en;
    fr       = slave ? fr_rx : fr_gen;
    fr_out   = fr_gen;
    dof_out  = disp_on;
    disp_en  = slave ? dof_in : disp_on;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cl_out <= 1'b0;
    else             cl_out <= cl_out_d;
  end

  a_r1_osc_master_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    osc_en |-> strap_master && strap_int_clk && cl_oe);
  a_r2_master_drives: assert property (@(posedge clk) disable iff (!rst_sync_n)
    strap_master |-> fr_oe && dof_oe && (cl_oe == strap_int_clk));
  a_r3_slave_inputs: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !strap_master |-> !fr_oe && !cl_oe && !dof_oe && !osc_en);
  a_r9_cl_with_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cl_out |-> line_strobe);
endmodule

// File: tb/test_lcd_frame_timing.sv
module test_lcd_frame_timing;
  localparam int LINES = 7;
  localparam int LW    = $clog2(LINES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_master = 1'b1, strap_int_clk = 1'b1;
  logic osc_tick = 1'b0, cl_in = 1'b0, fr_in = 1'b0, dof_in = 1'b0, disp_on = 1'b0;
  logic osc_en, cl_oe, fr_oe, dof_oe, cl_out, fr_out, dof_out, fr, disp_en, line_strobe;
  logic [LW-1:0] line_idx;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_line;
  logic exp_fr;

  always #4 clk = ~clk;

  lcd_frame_timing #(.LINES(LINES)) i_lcd_frame_timing (
    .clk(clk), .rst_n(rst_n), .strap_master(strap_master), .strap_int_clk(strap_int_clk),
    .osc_tick(osc_tick), .cl_in(cl_in), .fr_in(fr_in), .dof_in(dof_in), .disp_on(disp_on),
    .osc_en(osc_en), .cl_oe(cl_oe), .fr_oe(fr_oe), .dof_oe(dof_oe), .cl_out(cl_out),
    .fr_out(fr_out), .dof_out(dof_out), .fr(fr), .disp_en(disp_en),
    .line_idx(line_idx), .line_strobe(line_strobe)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic m, logic c);
    @(negedge clk);
    rst_n = 1'b0; strap_master = m; strap_int_clk = c;
    osc_tick = 0; cl_in = 0; fr_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_line = 1; exp_fr = 0;
  endtask

  // kind 0: osc tick, kind 1: cl_in rising edge; active = event expected to count
  task automatic line_event(int kind, bit active, bit fr_flip);
    @(negedge clk);
    if (kind == 0) osc_tick = 1; else cl_in = 1;
    if (fr_flip) fr_in = ~fr_in;
    if (fr_flip && !strap_master) exp_line = 1;
    else if (active) begin
      if (exp_line == LINES) begin
        exp_line = 1;
        if (strap_master) exp_fr = ~exp_fr;
      end else exp_line++;
    end
    if (!strap_master) exp_fr = fr_in;
    @(posedge clk); #2;
    check(fr_flip ? "R10 line" : (exp_line == 1 ? "R7 line" : "R6 line"), line_idx, exp_line);
    check("R6 strobe", line_strobe, active);
    check(strap_master ? "R8 fr" : "R10 fr", fr, exp_fr);
    check("R9 cl_out", cl_out, active && osc_en);
    @(negedge clk);
    osc_tick = 0; cl_in = 0;
    @(posedge clk); #2;
    check("R6 strobe drop", line_strobe, 0);
    check("R6 hold", line_idx, exp_line);
  endtask

  initial begin
    #1500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // Strap decode sweep: R1, R2, R3, R11
    for (int s = 0; s < 4; s++) begin
      strap_master = s[1]; strap_int_clk = s[0];
      for (int d = 0; d < 4; d++) begin
        disp_on = d[0]; dof_in = d[1];
        #1;
        check("R1 osc_en", osc_en, s[1] & s[0]);
        check(s[1] ? "R2 fr_oe" : "R3 fr_oe", fr_oe, s[1]);
        check(s[1] ? "R2 dof_oe" : "R3 dof_oe", dof_oe, s[1]);
        check(s[1] ? "R2 cl_oe" : "R3 cl_oe", cl_oe, s[1] & s[0]);
        check("R11 dof_out", dof_out, d[0]);
        check("R11 disp_en", disp_en, s[1] ? d[0] : d[1]);
      end
    end

    // Master, internal oscillator
    do_reset(1, 1);
    check("R5 line", line_idx, 1);
    check("R5 fr", fr, 0);
    check("R5 strobe", line_strobe, 0);
    check("R5 cl_out", cl_out, 0);
    for (int i = 0; i < 3 * LINES + 2; i++) line_event(0, 1, 0);
    check("R8 fr_out", fr_out, exp_fr);
    for (int i = 0; i < 3; i++) line_event(1, 0, 0);   // R4 cl_in ignored

    // Master, external line clock
    do_reset(1, 0);
    for (int i = 0; i < 2 * LINES + 3; i++) line_event(1, 1, 0);
    for (int i = 0; i < 3; i++) line_event(0, 0, 0);   // R4 osc_tick ignored

    // Slave: follows received FR, restarts on its changes
    do_reset(0, 0);
    for (int i = 0; i < LINES + 3; i++) line_event(1, 1, 0);
    for (int i = 0; i < 3; i++) line_event(1, 1, 0);
    line_event(1, 1, 1);                                // R10 restart with event
    for (int i = 0; i < 2; i++) line_event(1, 1, 0);
    @(negedge clk); fr_in = ~fr_in; exp_line = 1; exp_fr = fr_in;
    @(posedge clk); #2;
    check("R10 restart alone", line_idx, 1);
    check("R10 fr follows", fr, exp_fr);
    check("R10 no strobe", line_strobe, 0);
    for (int i = 0; i < LINES + 1; i++) line_event(1, 1, 0);
    for (int i = 0; i < 2; i++) line_event(0, 0, 0);   // R4 tick ignored in slave

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule